// File: doc/BRIEF.md
# Push-Button Debouncer

This block turns one raw, bouncing push-button signal into a clean level. It samples the button on every rising clock edge and compares each new value with the one taken a cycle earlier. Any difference restarts a down-counter loaded with the stable interval. Matching samples count it down, and it stops at zero. Once the counter has reached zero, the registered output copies the stored earlier sample, never the live pin. Contact chatter shorter than the interval therefore never reaches the output.

The interval is the elaboration-time parameter `STABLE_CYCLES`, which must be 1 or more. The counter is `$clog2(STABLE_CYCLES+1)` bits wide. As a sizing example, 100 ms at a 12 MHz clock needs 1,200,000 cycles. Reset is synchronous and active high. The block has no synchronizer chain, so the raw input is expected to be synchronous to the clock already.

Top module: `btn_debounce`

## Requirements
- R1: While `rst` is high at a rising edge, the output and the previous-sample register clear to 0 and the counter loads `STABLE_CYCLES`; after the last reset edge the output reads 0.
- R2: On every non-reset rising edge the previous-sample register takes the current raw input, and the output only ever copies that register, never the live input.
- R3: When the raw input differs from the previous sample at an edge, the counter reloads `STABLE_CYCLES`, so a new level must again stay for the full interval.
- R4: When the raw input equals the previous sample and the counter is non-zero, the counter drops by exactly one.
- R5: When the raw input equals the previous sample and the counter is zero, the counter stays at zero and does not wrap; after any long stable stretch, a new level is still followed after exactly `STABLE_CYCLES`+1 edges.
- R6: At an edge where the counter is zero, the output takes the previous sample. A level first sampled at edge e and held through edge e+`STABLE_CYCLES` appears on the output after edge e+`STABLE_CYCLES`+1.
- R7: While the counter is non-zero, the output keeps its value. A change held for `STABLE_CYCLES` edges or fewer leaves the output unchanged (with an interval of 3, a change held for 2 cycles is ignored).
- R8: `STABLE_CYCLES` must be at least 1, and the counter never holds a value above it.
- R9: With the smallest interval of 1, a level held for 2 edges is accepted and a single-edge change is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btnRaw | input | 1 | Raw button level, possibly bouncing |
| btnClean | output | 1 | Debounced, registered button level |

## Verification
A level first sampled at edge e is due on `btnClean` after edge e+`STABLE_CYCLES`+1, and a change that lasts `STABLE_CYCLES` edges or fewer is never due at all. The bench drives the input at falling edges. It records the value applied at each rising edge, with the reset edge stored as 0. After every rising edge it samples the output at the following falling edge. The expected level is recomputed from the recorded history: the output moves to the value of edge t-1 once the last `STABLE_CYCLES`+1 recorded values all agree. A sweep over every 12-bit input pattern runs against an interval-3 instance and an interval-1 instance together. Directed sequences check the exact edge of each transition with literal values.

// File: rtl/btn_debounce_pkg.sv
package btn_debounce_pkg;

  // Per-cycle commands from control to datapath.
  typedef struct packed {
    logic reload;    // input moved: restart the stable interval
    logic decrement; // input steady and counter not yet exhausted
    logic capture;   // interval exhausted: output follows stored sample
  } dbStrobe_t;

  // Counter width able to hold an interval value.
  function automatic int dbCountWidth(input int interval);
    return (interval < 1) ? 1 : $clog2(interval + 1);
  endfunction

endpackage

// File: rtl/btn_debounce_ctrl.sv
module btn_debounce_ctrl
  import btn_debounce_pkg::*;
(
  input  logic      rawIn,
  input  logic      sampleQ,
  input  logic      countZero,
  output dbStrobe_t strobe
);

  logic inputMoved;

  always_comb begin
    inputMoved       = (rawIn != sampleQ);
    strobe.reload    = inputMoved;
    strobe.decrement = !inputMoved && !countZero;
    strobe.capture   = countZero;
  end

endmodule

// File: rtl/btn_debounce_dp.sv
module btn_debounce_dp
  import btn_debounce_pkg::*;
#(
  parameter int STABLE_CYCLES = 16,
  localparam int CNT_W = dbCountWidth(STABLE_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rawIn,
  input  dbStrobe_t        strobe,
  output logic             sampleQ,
  output logic [CNT_W-1:0] countQ,
  output logic             countZero,
  output logic             levelQ
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STABLE_CYCLES);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  // One-cycle history of the raw input.
  always_ff @(posedge clk) begin
    if (rst) sampleQ <= 1'b0;
    else     sampleQ <= rawIn;
  end

  // Stable-interval down-counter, saturating at zero.
  always_ff @(posedge clk) begin
    if (rst)                   countQ <= LOAD_VAL;
    else if (strobe.reload)    countQ <= LOAD_VAL;
    else if (strobe.decrement) countQ <= countQ - ONE;
  end

  assign countZero = (countQ == '0);

  // Registered clean level, fed only from the stored sample.
  always_ff @(posedge clk) begin
    if (rst)                 levelQ <= 1'b0;
    else if (strobe.capture) levelQ <= sampleQ;
  end

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce
  import btn_debounce_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRaw,
  output logic btnClean
);

  localparam int CNT_W = dbCountWidth(STABLE_CYCLES);

  dbStrobe_t        strobe;
  logic             sampleQ;
  logic [CNT_W-1:0] countQ;
  logic             countZero;

  btn_debounce_ctrl u_ctrl (
    .rawIn     (btnRaw),
    .sampleQ   (sampleQ),
    .countZero (countZero),
    .strobe    (strobe)
  );

  btn_debounce_dp #(
    .STABLE_CYCLES (STABLE_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .rawIn     (btnRaw),
    .strobe    (strobe),
    .sampleQ   (sampleQ),
    .countQ    (countQ),
    .countZero (countZero),
    .levelQ    (btnClean)
  );

endmodule

// File: rtl/btn_debounce_chk.sv
module btn_debounce_chk #(
  parameter int STABLE_CYCLES = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             btnRaw,
  input logic             sampleQ,
  input logic [CNT_W-1:0] countQ,
  input logic             btnClean
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STABLE_CYCLES);

  initial AST_INTERVAL_MIN: assert (STABLE_CYCLES >= 1); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (countQ == LOAD_VAL && btnClean == 1'b0 && sampleQ == 1'b0)); // R1

  AST_SAMPLE_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sampleQ == $past(btnRaw)); // R2

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (btnRaw != sampleQ) |=> countQ == LOAD_VAL); // R3

  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (btnRaw == sampleQ && countQ != '0) |=> countQ == $past(countQ) - CNT_W'(1)); // R4

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (btnRaw == sampleQ && countQ == '0) |=> countQ == '0); // R5

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (countQ == '0) |=> btnClean == $past(sampleQ)); // R6

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (countQ != '0) |=> $stable(btnClean)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    countQ <= LOAD_VAL); // R8

endmodule

bind btn_debounce btn_debounce_chk #(
  .STABLE_CYCLES (STABLE_CYCLES),
  .CNT_W         (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .btnRaw   (btnRaw),
  .sampleQ  (sampleQ),
  .countQ   (countQ),
  .btnClean (btnClean)
);

// File: tb/tb_btn_debounce.sv
module tb_btn_debounce;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 3;
  localparam int NB = 1;
  localparam int PAT_BITS = 12;
  localparam int RUN_EDGES = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnRaw = 1'b0;
  logic outA, outB;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  bit  hist [0:127];
  int  t;
  bit  expA, expB;

  always #(CLK_PERIOD/2) clk = ~clk;

  btn_debounce #(.STABLE_CYCLES(NA)) dut    (.clk(clk), .rst(rst), .btnRaw(btnRaw), .btnClean(outA));
  btn_debounce #(.STABLE_CYCLES(NB)) dutMin (.clk(clk), .rst(rst), .btnRaw(btnRaw), .btnClean(outB));

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0b expected %0b", req, t, act, exp);
    end
  endtask

  // Expected level after edge t from the recorded history and interval n.
  function automatic bit windowExp(input int n, input bit prevExp);
    bit same;
    if (t - n - 1 < 0) return prevExp;
    same = 1'b1;
    for (int k = t - n - 1; k < t; k++)
      if (hist[k] != hist[t-1]) same = 1'b0;
    return same ? hist[t-1] : prevExp;
  endfunction

  // Called at a falling edge: apply v, pass one rising edge, return at the next falling edge.
  task automatic edgeStep(input bit v);
    btnRaw = v;
    @(posedge clk);
    t++;
    hist[t] = v;
    expA = windowExp(NA, expA);
    expB = windowExp(NB, expB);
    @(negedge clk);
    check(outA, expA, "R6/R7 interval 3");
    check(outB, expB, "R9 interval 1");
  endtask

  task automatic doReset();
    rst = 1'b1;
    btnRaw = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t = 0;
    hist[0] = 1'b0;
    expA = 1'b0;
    expB = 1'b0;
    check(outA, 1'b0, "R1 reset level interval 3");
    check(outB, 1'b0, "R1 reset level interval 1");
  endtask

  initial begin
    @(negedge clk);
    doReset();

    // Level held from edge 1: interval 1 output after edge 3, interval 3 after edge 5.
    edgeStep(1'b1); edgeStep(1'b1);
    check(outB, 1'b0, "R9 not yet after 2 edges");
    edgeStep(1'b1);
    check(outB, 1'b1, "R9 accepted after 3rd edge");
    edgeStep(1'b1);
    check(outA, 1'b0, "R4 counter still running after edge 4");
    edgeStep(1'b1);
    check(outA, 1'b1, "R6 accepted after edge 5");
    check(outA, hist[t-1], "R2 output equals stored sample");

    // Two-cycle glitch low then back high: ignored by interval 3.
    edgeStep(1'b0); edgeStep(1'b0);
    check(outA, 1'b1, "R7 two-cycle glitch ignored");
    for (int i = 0; i < 6; i++) edgeStep(1'b1);
    check(outA, 1'b1, "R7 output unchanged after glitch");

    // Single-edge glitch on interval 1: ignored.
    edgeStep(1'b0);
    edgeStep(1'b1);
    check(outB, 1'b1, "R9 single-edge change ignored");
    edgeStep(1'b1);
    check(outB, 1'b1, "R9 level kept");

    // Reload: low for 3, high 1, then low from edge e0; output falls after e0+4.
    edgeStep(1'b0); edgeStep(1'b0); edgeStep(1'b0);
    edgeStep(1'b1);
    for (int i = 0; i < 4; i++) edgeStep(1'b0);
    check(outA, 1'b1, "R3 interval restarted by change");
    edgeStep(1'b0);
    check(outA, 1'b0, "R3 accepted a full interval after last change");

    // Long stable stretch, then a new level must still need exactly 4 more edges.
    for (int i = 0; i < 20; i++) edgeStep(1'b0);
    for (int i = 0; i < 4; i++) edgeStep(1'b1);
    check(outA, 1'b0, "R5 no early acceptance after long hold");
    edgeStep(1'b1);
    check(outA, 1'b1, "R5 acceptance exactly N+1 edges later");

    // Reset while the output is high.
    doReset();

    // Exhaustive sweep of input patterns for both intervals.
    for (int p = 0; p < (1 << PAT_BITS); p++) begin
      doReset();
      for (int i = 0; i < RUN_EDGES; i++) begin
        int idx;
        idx = (i < PAT_BITS) ? i : PAT_BITS - 1;
        edgeStep(p[idx]);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule